// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the word address for each beat of a four-beat burst into a cache data memory. One of two address strobes, a processor-side one and a controller-side one, captures a full word address. The upper bits of that address are kept as the burst base. The two low bits become the start offset of the burst. Each cycle in which the step input is high moves the burst to its next beat. The low address bits are then recomputed from the start offset and the beat count.

A static order-select level picks how the low bits evolve. When it is low they wrap upward, as in start plus beat modulo four. When it is high they follow start XOR beat. The order level feeds only combinational logic, so the presented address follows that level directly without a clock edge. A registered flag marks the fourth beat of every group of four. If stepping continues past that beat, the sequence wraps and carries on.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the block returns to the state where `word_addr` is 0 and `last_beat` is 0 after that edge.
- R2: When `strobe_cpu` or `strobe_ctl` (or both) is high at a rising edge, `word_addr` equals `addr_in` after that edge, the beat count restarts at 0, and `last_beat` is 0.
- R3: A strobe takes priority over `advance`: when both are high at the same edge, the address loads and no step occurs.
- R4: With `order_sel` = 0 (linear), bits [1:0] of `word_addr` equal (start offset + beat count) mod 4, for example 2,3,0,1 from a start of 2.
- R5: With `order_sel` = 1 (interleaved), bits [1:0] of `word_addr` equal start offset XOR beat count, for example 1,0,3,2 from a start of 1.
- R6: When neither strobe nor `advance` is high at an edge, `word_addr` and `last_beat` hold their values, and `addr_in` has no effect.
- R7: After four steps the beat count wraps to 0, and stepping continues through the sequence again.
- R8: `last_beat` is 1 exactly while the beat count is 3, which is the fourth beat after a load.
- R9: `order_sel` is not registered. Changing it changes bits [1:0] of `word_addr` in the same cycle, without a clock edge.
- R10: The upper address bits (above bit 1) change only on a strobe and never on a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_cpu | input | 1 | Processor-side burst start strobe |
| strobe_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | Static order level: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Start word address |
| word_addr | output | ADDR_W | Current beat word address |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The bench uses odd and even start offsets in both orders. This exposes a design that adds where it should XOR, or the reverse, because the two orders agree only for even starts. It drives a strobe together with `advance`, and a start address of all ones. A counter that stepped on the load edge would show offset 0 instead of 3. A base that was incremented on a carry out of the low bits would corrupt the upper bits. It also steps past the fourth beat, holds with a changing `addr_in`, flips `order_sel` with no clock edge, and resets in mid-burst. These tests catch, in turn, a counter that stops, a flag that stays high, a leaky address capture, a registered order level, and stale state after reset.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned BEAT_W = 2;
    localparam int unsigned BEATS  = 1 << BEAT_W;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic              last;
    } beat_state_t;

endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);

    localparam logic [BEAT_W-1:0] FINAL_BEAT = BEAT_W'(BEATS - 1);

    beat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.beat = '0;
        end else if (step) begin
            st_d.beat = st_q.beat + 1'b1;
        end
        st_d.last = (st_d.beat == FINAL_BEAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat = st_q.beat;
    assign last = st_q.last;

    p_load_restart_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (beat == '0) && !last);

    p_step_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> (beat == BEAT_W'($past(beat) + 1'b1)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> ($stable(beat) && $stable(last)));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-BEAT_W-1:0] upper,
    output logic [BEAT_W-1:0]        start
);

    localparam int unsigned UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] start;
    } base_t;

    base_t base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (load) begin
            base_d.upper = addr_in[ADDR_W-1:BEAT_W];
            base_d.start = addr_in[BEAT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign upper = base_q.upper;
    assign start = base_q.start;

    p_upper_only_on_load_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(upper) && $stable(start)));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  order_e            order,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] offset
);

    logic [BEAT_W-1:0] lin_off;
    logic [BEAT_W-1:0] xor_off;

    assign lin_off = start + beat;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign xor_off[b] = start[b] ^ beat[b];
    end

    always_comb begin
        case (order)
            ORDER_INTERLEAVE: offset = xor_off;
            default:          offset = lin_off;
        endcase
    end

    always_comb begin
        if (beat == '0) begin
            p_first_beat_is_start_r4: assert (offset == start);
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic              last_beat
);

    localparam int unsigned UP_W = ADDR_W - BEAT_W;

    logic              load;
    logic [UP_W-1:0]   upper;
    logic [BEAT_W-1:0] start;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] offset;
    order_e            order;

    assign load  = strobe_cpu | strobe_ctl;
    assign order = order_e'(order_sel);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_in (addr_in),
        .upper   (upper),
        .start   (start)
    );

    burst_beat_counter u_count (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (advance),
        .beat (beat),
        .last (last_beat)
    );

    burst_order_map u_map (
        .order  (order),
        .start  (start),
        .beat   (beat),
        .offset (offset)
    );

    assign word_addr = {upper, offset};

    p_load_addr_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (word_addr == $past(addr_in)));

    p_strobe_priority_r3: assert property (@(posedge clk) disable iff (rst)
        (load && advance) |=> !last_beat);

    p_last_needs_step_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(last_beat) |-> $past(advance));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int unsigned AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_cpu = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;
    logic          last_beat;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .advance    (advance),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .word_addr  (word_addr),
        .last_beat  (last_beat)
    );

    typedef struct packed {
        logic          cpu;
        logic          ctl;
        logic          adv;
        logic          mode;
        logic [AW-1:0] ain;
        logic [AW-1:0] exp_addr;
        logic          exp_last;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 15'h1232, 15'h1232, 1'b0}, // R2 cpu strobe
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h1233, 1'b0}, // R4
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h1230, 1'b0}, // R4 R10
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h1231, 1'b1}, // R8
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h1232, 1'b0}, // R7 wrap
        '{1'b0, 1'b0, 1'b0, 1'b0, 15'h7777, 15'h1232, 1'b0}, // R6 hold
        '{1'b0, 1'b1, 1'b0, 1'b1, 15'h0ABD, 15'h0ABD, 1'b0}, // R2 ctl strobe
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0ABC, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0ABF, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0ABE, 1'b1}, // R5 R8
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0ABD, 1'b0}, // R7
        '{1'b1, 1'b0, 1'b1, 1'b0, 15'h7FFF, 15'h7FFF, 1'b0}, // R3
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h7FFC, 1'b0}, // R10 no carry
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h7FFD, 1'b0}, // R4
        '{1'b0, 1'b0, 1'b1, 1'b0, 15'h0000, 15'h7FFE, 1'b1}, // R8
        '{1'b1, 1'b1, 1'b0, 1'b1, 15'h0002, 15'h0002, 1'b0}, // R2 both
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0003, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0000, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 15'h0001, 1'b1}, // R8
        '{1'b0, 1'b0, 1'b0, 1'b1, 15'h5555, 15'h0001, 1'b1}  // R6 addr ignored
    };

    task automatic check(input string tag, input logic [AW-1:0] got_a, input logic got_l,
                         input logic [AW-1:0] exp_a, input logic exp_l);
        checks++;
        if (got_a !== exp_a || got_l !== exp_l) begin
            errors++;
            $display("FAIL %s: actual addr=%h last=%b expected addr=%h last=%b",
                     tag, got_a, got_l, exp_a, exp_l);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset state", word_addr, last_beat, '0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            strobe_cpu = VECS[i].cpu;
            strobe_ctl = VECS[i].ctl;
            advance    = VECS[i].adv;
            order_sel  = VECS[i].mode;
            addr_in    = VECS[i].ain;
            @(posedge clk);
            #5;
            check($sformatf("R2-R8 vector %0d", i), word_addr, last_beat,
                  VECS[i].exp_addr, VECS[i].exp_last);
        end

        // R9: order level acts without a clock edge
        strobe_cpu = 1'b1; advance = 1'b0; order_sel = 1'b0; addr_in = 15'h0001;
        @(posedge clk); #5;
        strobe_cpu = 1'b0; advance = 1'b1;
        @(posedge clk); #5;
        advance = 1'b0;
        check("R4 linear step from 1", word_addr, last_beat, 15'h0002, 1'b0);
        order_sel = 1'b1;
        #1;
        check("R9 order flip no clock", word_addr, last_beat, 15'h0000, 1'b0);
        order_sel = 1'b0;
        #1;
        check("R9 order flip back", word_addr, last_beat, 15'h0002, 1'b0);

        // R1: reset in mid-burst
        advance = 1'b1;
        @(posedge clk); #5;
        @(posedge clk); #5;
        check("R8 last before reset", word_addr, last_beat, 15'h0000, 1'b1);
        rst = 1'b1;
        @(posedge clk); #5;
        check("R1 mid-burst reset", word_addr, last_beat, '0, 1'b0);
        rst = 1'b0; advance = 1'b0;
        @(posedge clk); #5;
        check("R6 hold after reset", word_addr, last_beat, '0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule